// File: doc/BRIEF.md
# Prefetch Pollution Filter Table

This block sits in front of a prefetch queue and decides, for each candidate prefetch, whether it goes out or is dropped. It keeps a table of 2-bit saturating confidence counters. Each candidate is mapped to one counter by XOR-folding a key. A parameter chooses the key. In per-address mode the key is the cache line address of the prefetch. In per-PC mode the key is a program counter: the PC of a software prefetch instruction, or the PC of the memory instruction that triggered a hardware prefetch.

When a prefetched line leaves the cache, the cache reports whether the line was referenced while it was resident. That report comes back on the training port with the key that was recorded when the prefetch was issued. A used line raises its counter and an unused line lowers it, so keys whose prefetches keep going to waste are filtered out. The table size is a parameter, because per-address use needs more entries than per-PC use to keep aliasing low.

Top module: `pf_filter`

## Requirements
- R1: After reset every counter holds 2, so any query made before training returns issue.
- R2: A query presented with `q_valid` high at a clock edge gives `rsp_valid` high for exactly the following cycle, with the decision on `rsp_issue`. When no query was presented at that edge, `rsp_valid` is low.
- R3: `rsp_issue` is 1 when the selected counter is 2 or 3, and 0 when it is 0 or 1.
- R4: A training report with `u_used` = 1 adds one to the selected counter, which then stays at 3.
- R5: A training report with `u_used` = 0 subtracts one from the selected counter, which then stays at 0.
- R6: In per-address mode (`MODE` = 0), the key is shifted right by 5. Bit j of the shifted key is XORed into index bit (j mod log2(ENTRIES)). As a result, the 5 line-offset bits have no effect, and keys that differ by pairs of bits mapping to the same index bit share a counter.
- R7: In per-PC mode (`MODE` = 1), the same fold is used with a shift of 2. PCs that differ only in bits 1:0 share a counter, and PCs that differ in bit 2 use different counters.
- R8: When a query and a training report select the same counter in the same cycle, the response is based on the counter value from before the update, and the update still takes effect.
- R9: A training report changes only the counter its own key folds to. Queries whose keys fold to other indices keep their earlier decision.

Top module ports are listed in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| q_valid | input | 1 | A candidate prefetch is presented |
| q_key | input | KEY_W | Line address or PC of the candidate, depending on `MODE` |
| rsp_valid | output | 1 | The decision for the previous cycle's query is valid |
| rsp_issue | output | 1 | 1 = issue the prefetch, 0 = drop it |
| u_valid | input | 1 | A prefetched line was evicted and its outcome is reported |
| u_key | input | KEY_W | Key that was recorded when that prefetch was issued |
| u_used | input | 1 | 1 = the line was referenced before eviction, 0 = it was never referenced |

## Verification
The bench builds two instances, each with `ENTRIES` = 64 and a 32-bit key. One uses per-address mode and the other uses per-PC mode. With only 64 counters, deliberately aliasing keys are easy to construct, so the bench can show that offset bits are dropped and that folded bits land on a shared counter. With a small table, a handful of training reports also drives a counter to each saturation limit and back across the issue threshold. The per-PC instance covers the narrower shift, and a same-cycle query and update on one counter exercises the read-before-write ordering.

// File: rtl/pf_filter_pkg.sv
package pf_filter_pkg;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_INIT = 2'd2;
  localparam ctr_t CTR_MAX  = 2'd3;
  localparam ctr_t CTR_MIN  = 2'd0;

  // Saturating training step: used lines raise confidence, unused lines lower it.
  function automatic ctr_t ctr_train(input ctr_t c, input logic used);
    if (used)
      return (c == CTR_MAX) ? CTR_MAX : c + 2'd1;
    else
      return (c == CTR_MIN) ? CTR_MIN : c - 2'd1;
  endfunction

  // Issue threshold: the upper half of the counter range.
  function automatic logic ctr_allows(input ctr_t c);
    return c[1];
  endfunction

endpackage

// File: rtl/pf_key_fold.sv
module pf_key_fold #(
  parameter int KEY_W = 32,
  parameter int IDX_W = 12,
  parameter int SHIFT = 5
) (
  input  logic [KEY_W-1:0] key,
  output logic [IDX_W-1:0] idx
);

  // Every key bit at or above SHIFT is XORed into index bit (position mod IDX_W).
  function automatic logic [IDX_W-1:0] fold(input logic [KEY_W-1:0] k);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = SHIFT; i < KEY_W; i++) begin
      r[(i - SHIFT) % IDX_W] = r[(i - SHIFT) % IDX_W] ^ k[i];
    end
    return r;
  endfunction

  assign idx = fold(key);

endmodule

// File: rtl/pf_ctr_table.sv
module pf_ctr_table
  import pf_filter_pkg::*;
#(
  parameter int ENTRIES = 4096,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr_t             rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_used,
  output ctr_t             wr_old
);

  ctr_t mem [ENTRIES];
  ctr_t wr_new;

  // Both reads happen before the clock edge, so a same-index query sees the old value.
  assign rd_ctr = mem[rd_idx];
  assign wr_old = mem[wr_idx];
  assign wr_new = ctr_train(wr_old, wr_used);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) mem[i] <= CTR_INIT;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_new;
    end
  end

  // Observation of the last write, kept only for the assertions below.
  logic             chk_v;
  logic [IDX_W-1:0] chk_idx;
  ctr_t             chk_old;
  logic             chk_used;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_v    <= 1'b0;
      chk_idx  <= '0;
      chk_old  <= CTR_INIT;
      chk_used <= 1'b0;
    end else begin
      chk_v    <= wr_en;
      chk_idx  <= wr_idx;
      chk_old  <= wr_old;
      chk_used <= wr_used;
    end
  end

  assert_step_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
    chk_v && chk_used && chk_old != CTR_MAX |-> mem[chk_idx] == chk_old + 2'd1);

  assert_hold_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    chk_v && chk_used && chk_old == CTR_MAX |-> mem[chk_idx] == CTR_MAX);

  assert_step_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
    chk_v && !chk_used && chk_old != CTR_MIN |-> mem[chk_idx] == chk_old - 2'd1);

  assert_hold_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    chk_v && !chk_used && chk_old == CTR_MIN |-> mem[chk_idx] == CTR_MIN);

endmodule

// File: rtl/pf_filter.sv
module pf_filter
  import pf_filter_pkg::*;
#(
  parameter int ENTRIES    = 4096,
  parameter int KEY_W      = 32,
  parameter int MODE       = 0,
  parameter int LINE_OFF_W = 5,
  parameter int WORD_OFF_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             q_valid,
  input  logic [KEY_W-1:0] q_key,
  output logic             rsp_valid,
  output logic             rsp_issue,
  input  logic             u_valid,
  input  logic [KEY_W-1:0] u_key,
  input  logic             u_used
);

  localparam int IDX_W = $clog2(ENTRIES);
  localparam int SHIFT = (MODE == 0) ? LINE_OFF_W : WORD_OFF_W;

  logic [IDX_W-1:0] q_idx;
  logic [IDX_W-1:0] u_idx;
  ctr_t             q_ctr;
  ctr_t             u_old;
  logic             same_idx_hit;

  pf_key_fold #(.KEY_W(KEY_W), .IDX_W(IDX_W), .SHIFT(SHIFT)) u_fold_q (
    .key(q_key), .idx(q_idx)
  );

  pf_key_fold #(.KEY_W(KEY_W), .IDX_W(IDX_W), .SHIFT(SHIFT)) u_fold_u (
    .key(u_key), .idx(u_idx)
  );

  pf_ctr_table #(.ENTRIES(ENTRIES)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_idx  (q_idx),
    .rd_ctr  (q_ctr),
    .wr_en   (u_valid),
    .wr_idx  (u_idx),
    .wr_used (u_used),
    .wr_old  (u_old)
  );

  assign same_idx_hit = q_valid && u_valid && (q_idx == u_idx);

  logic r_valid;
  ctr_t r_ctr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_valid <= 1'b0;
      r_ctr   <= CTR_INIT;
    end else begin
      r_valid <= q_valid;
      if (q_valid) r_ctr <= q_ctr;
    end
  end

  assign rsp_valid = r_valid;
  assign rsp_issue = r_valid && ctr_allows(r_ctr);

  assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid |=> rsp_valid);

  assert_rsp_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !q_valid |=> !rsp_valid);

  assert_old_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
    same_idx_hit |=> r_ctr == $past(u_old));

  assert_no_issue_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !rsp_issue);

endmodule

// File: tb/pf_filter_test.sv
module pf_filter_test;

  localparam int TB_ENTRIES = 64;
  localparam int TB_IW      = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        a_qv = 0, a_uv = 0, a_used = 0;
  logic [31:0] a_qk = 0, a_uk = 0;
  logic        a_rv, a_ri;
  logic        p_qv = 0, p_uv = 0, p_used = 0;
  logic [31:0] p_qk = 0, p_uk = 0;
  logic        p_rv, p_ri;

  pf_filter #(.ENTRIES(TB_ENTRIES), .KEY_W(32), .MODE(0)) uut (
    .clk(clk), .rst_n(rst_n), .q_valid(a_qv), .q_key(a_qk),
    .rsp_valid(a_rv), .rsp_issue(a_ri),
    .u_valid(a_uv), .u_key(a_uk), .u_used(a_used)
  );

  pf_filter #(.ENTRIES(TB_ENTRIES), .KEY_W(32), .MODE(1)) uut_pc (
    .clk(clk), .rst_n(rst_n), .q_valid(p_qv), .q_key(p_qk),
    .rsp_valid(p_rv), .rsp_issue(p_ri),
    .u_valid(p_uv), .u_key(p_uk), .u_used(p_used)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int model_a [TB_ENTRIES];
  int model_p [TB_ENTRIES];

  function automatic int bidx(input logic [31:0] key, input int shift);
    logic [31:0] k;
    int r;
    k = key >> shift;
    r = 0;
    while (k != 0) begin
      r = r ^ int'(k[TB_IW-1:0]);
      k = k >> TB_IW;
    end
    return r;
  endfunction

  function automatic int trained(input int v, input logic used);
    if (used) return (v >= 3) ? 3 : v + 1;
    return (v <= 0) ? 0 : v - 1;
  endfunction

  task automatic check(input string req, input logic act, input logic exp, input string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  function automatic logic expect_issue(input int sel, input logic [31:0] key);
    if (sel == 0) return model_a[bidx(key, 5)] >= 2;
    return model_p[bidx(key, 2)] >= 2;
  endfunction

  task automatic query(input int sel, input logic [31:0] key, input string req);
    logic exp;
    exp = expect_issue(sel, key);
    @(negedge clk);
    if (sel == 0) begin a_qv = 1; a_qk = key; end
    else begin p_qv = 1; p_qk = key; end
    @(negedge clk);
    a_qv = 0; p_qv = 0;
    if (sel == 0) begin
      check(req, a_rv, 1'b1, "rsp_valid");
      check(req, a_ri, exp, "rsp_issue");
    end else begin
      check(req, p_rv, 1'b1, "rsp_valid");
      check(req, p_ri, exp, "rsp_issue");
    end
  endtask

  task automatic train(input int sel, input logic [31:0] key, input logic used);
    @(negedge clk);
    if (sel == 0) begin
      a_uv = 1; a_uk = key; a_used = used;
      model_a[bidx(key, 5)] = trained(model_a[bidx(key, 5)], used);
    end else begin
      p_uv = 1; p_uk = key; p_used = used;
      model_p[bidx(key, 2)] = trained(model_p[bidx(key, 2)], used);
    end
    @(negedge clk);
    a_uv = 0; p_uv = 0;
  endtask

  localparam logic [31:0] KA = 32'h0000_1240;
  localparam logic [31:0] KB = 32'h0000_0060;

  task automatic t_reset;
    for (int i = 0; i < TB_ENTRIES; i++) begin model_a[i] = 2; model_p[i] = 2; end
    rst_n = 0;
    repeat (3) @(negedge clk);
    check("R2", a_rv, 1'b0, "idle rsp_valid in reset");
    rst_n = 1;
    @(negedge clk);
    query(0, KA, "R1");
    query(0, 32'hDEAD_BEE0, "R1");
    query(1, 32'h0040_1000, "R1");
    @(negedge clk);
    check("R2", a_rv, 1'b0, "rsp_valid with no query");
    check("R2", a_ri, 1'b0, "rsp_issue with no query");
  endtask

  task automatic t_train_down;
    train(0, KA, 1'b0);
    query(0, KA, "R5");
    check("R3", a_ri, 1'b0, "counter 1 drops");
    train(0, KA, 1'b0);
    train(0, KA, 1'b0);
    train(0, KA, 1'b0);
    query(0, KA, "R5");
    train(0, KA, 1'b1);
    query(0, KA, "R5");
    train(0, KA, 1'b1);
    query(0, KA, "R3");
    check("R3", a_ri, 1'b1, "counter 2 issues");
  endtask

  task automatic t_train_up;
    for (int i = 0; i < 4; i++) train(0, KB, 1'b1);
    query(0, KB, "R4");
    train(0, KB, 1'b0);
    query(0, KB, "R4");
    check("R4", a_ri, 1'b1, "saturated at 3 then one unused");
    train(0, KB, 1'b0);
    query(0, KB, "R4");
    check("R4", a_ri, 1'b0, "two unused after saturation");
    query(0, KA, "R9");
  endtask

  task automatic t_alias;
    logic [31:0] kc, kd, ke;
    kc = KA ^ 32'h0000_0820;
    kd = KA | 32'h0000_001F;
    ke = KA ^ 32'h0000_0020;
    train(0, kc, 1'b0);
    train(0, kc, 1'b0);
    query(0, KA, "R6");
    check("R6", a_ri, 1'b0, "folded alias shares counter");
    query(0, kd, "R6");
    check("R6", a_ri, 1'b0, "offset bits ignored");
    query(0, ke, "R9");
    check("R9", a_ri, 1'b1, "neighbour index untouched");
  endtask

  task automatic t_pc_mode;
    logic [31:0] pk;
    pk = 32'h0000_4004;
    train(1, pk, 1'b0);
    train(1, pk, 1'b0);
    query(1, pk | 32'h3, "R7");
    check("R7", p_ri, 1'b0, "pc bits 1:0 ignored");
    query(1, pk ^ 32'h4, "R7");
    check("R7", p_ri, 1'b1, "pc bit 2 selects another counter");
    query(0, pk, "R7");
  endtask

  task automatic t_collision;
    logic exp_old;
    logic [31:0] kf;
    kf = 32'h0001_0000;
    exp_old = expect_issue(0, kf);
    @(negedge clk);
    a_qv = 1; a_qk = kf;
    a_uv = 1; a_uk = kf; a_used = 0;
    model_a[bidx(kf, 5)] = trained(model_a[bidx(kf, 5)], 1'b0);
    @(negedge clk);
    a_qv = 0; a_uv = 0;
    check("R8", a_rv, 1'b1, "collision rsp_valid");
    check("R8", a_ri, exp_old, "collision sees old value");
    query(0, kf, "R8");
    check("R8", a_ri, 1'b0, "update landed after collision");
  endtask

  bit done = 0;

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_train_down();
    t_train_up();
    t_alias();
    t_pc_mode();
    t_collision();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule